// File: doc/BRIEF.md
# CAN Node Error Confinement and Bus-Off Recovery

This block keeps the transmit and receive error counters of a CAN node and derives the node's fault-confinement state from them: error-active, warning, error-passive or bus-off. The counters and the three state flags are presented together in one 32-bit status word. A separate byte captures the details of the most recent bus error. The block emits single-cycle pulses when the prioritised state changes, when bus-off is first entered, and when recovery from bus-off completes.

The block is driven by single-cycle strobes from the protocol engine. Two strobes report errors, one on the transmit side and one on the receive side. Two more report successful frames, which lower the counters. A bit-time tick comes with the sampled bus level. A reset-mode level is supplied by the controller, and a bus-error strobe comes with its direction, type and frame segment.

Once the node is in bus-off and reset mode has been released, the block watches for a configurable number of idle conditions. Each idle condition is a run of consecutive recessive bits. When the last idle condition completes, the block clears both counters and leaves bus-off. In the same step it asks the transmit path to drain the entries that were aborted on entry to bus-off.

Top module: `can_err_state`

## Requirements
- R1: Status word layout: receive count in bits 7:0, transmit count in bits 15:8, warning flag at bit 17, error-passive flag at bit 18, bus-off flag at bit 19. Bit 16 and bits 31:20 always read 0.
- R2: Outside bus-off, each cycle with tx_err raises the transmit count by TX_STEP (8), and each cycle with rx_err raises the receive count by RX_STEP (1), saturating at 255. tx_ok and rx_ok lower their counter by 1 but never below 0. An error strobe takes precedence over a success strobe on the same counter in the same cycle.
- R3: The warning flag is 1 whenever either counter is at least WARN_LVL (96).
- R4: The error-passive flag is 1 whenever either counter is at least PASS_LVL (128).
- R5: A tx_err that would take the transmit count past 255 sets bus-off instead. The transmit field then reads 255, and all counter strobes are ignored until recovery.
- R6: state_evt pulses for exactly one cycle whenever the prioritised state changes. The priority order is bus-off, then error-passive, then warning, then error-active. The pulse coincides with the first cycle in which the status word shows the new state.
- R7: abort_all pulses for one cycle, in the first cycle that the status word shows bus-off.
- R8: While in bus-off with reset_mode high, no idle progress is made and any partial progress is discarded. With reset_mode low, each bit_tick with bit_recessive high extends the current run, and a tick with bit_recessive low restarts the run. Completed runs of IDLE_BITS recessive ticks are kept. Cycles without bit_tick do nothing.
- R9: When the IDLE_RUNS-th run completes, both counters and all flags clear together. In that first cleared cycle, drain_req and state_evt each pulse once.
- R10: On each berr strobe, err_code captures {berr_type, berr_rx, berr_seg}. berr_type occupies bits 7:6 (00 bit, 01 form, 10 stuff, 11 other), berr_rx is bit 5 (1 = error during reception), and berr_seg occupies bits 4:0. Without a berr strobe, err_code holds its value.
- R11: After reset, the status word and err_code are 0 and no pulse output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_err | input | 1 | Transmit error strobe |
| rx_err | input | 1 | Receive error strobe |
| tx_ok | input | 1 | Successful transmission strobe |
| rx_ok | input | 1 | Successful reception strobe |
| bit_tick | input | 1 | One pulse per bit time |
| bit_recessive | input | 1 | Sampled bus level at bit_tick, 1 = recessive |
| reset_mode | input | 1 | Controller held in reset mode |
| berr | input | 1 | Bus error strobe |
| berr_rx | input | 1 | Bus error occurred while receiving |
| berr_type | input | 2 | Bus error type code |
| berr_seg | input | 5 | Frame segment of the bus error |
| status | output | 32 | Packed counters and state flags |
| err_code | output | 8 | Last captured bus error code |
| state_evt | output | 1 | State change pulse |
| abort_all | output | 1 | Abort-all-pending-transmits pulse on bus-off entry |
| drain_req | output | 1 | Drain aborted transmit entries pulse at recovery end |

## Verification
The bench builds the block with IDLE_BITS=3 and IDLE_RUNS=4 and leaves the counter steps and thresholds at their defaults. With these values a full recovery takes only twelve recessive ticks. A pseudo-random stream of strobes and bus levels therefore drives the node into bus-off and back out many times, and it crosses the warning, passive and saturation boundaries in both directions; a cycle-by-cycle arithmetic model checks every output along the way. Directed sweeps add three more cases: a receive counter ramp past saturation and back to zero, a recovery with a dominant bit one tick before a run completes, and all 256 combinations of the bus-error fields.

// File: rtl/can_err_state.sv
module can_err_state #(
  parameter int TX_STEP   = 8,
  parameter int RX_STEP   = 1,
  parameter int WARN_LVL  = 96,
  parameter int PASS_LVL  = 128,
  parameter int IDLE_BITS = 11,
  parameter int IDLE_RUNS = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tx_err,
  input  logic        rx_err,
  input  logic        tx_ok,
  input  logic        rx_ok,
  input  logic        bit_tick,
  input  logic        bit_recessive,
  input  logic        reset_mode,
  input  logic        berr,
  input  logic        berr_rx,
  input  logic [1:0]  berr_type,
  input  logic [4:0]  berr_seg,
  output logic [31:0] status,
  output logic [7:0]  err_code,
  output logic        state_evt,
  output logic        abort_all,
  output logic        drain_req
);

  localparam int RUN_W  = $clog2(IDLE_BITS + 1);
  localparam int IDLE_W = $clog2(IDLE_RUNS + 1);
  localparam logic [8:0] WARN9 = 9'(WARN_LVL);
  localparam logic [8:0] PASS9 = 9'(PASS_LVL);
  localparam logic [1:0] ST_BUSOFF = 2'd3;

  logic [8:0]        tx_cnt;
  logic [7:0]        rx_cnt;
  logic              bus_off;
  logic [RUN_W-1:0]  run_cnt;
  logic [IDLE_W-1:0] idle_cnt;
  logic [1:0]        prev_st;
  logic              drain_q;
  logic [7:0]        code_q;

  wire [9:0] tx_sum = {1'b0, tx_cnt} + 10'(TX_STEP);
  wire [8:0] rx_sum = {1'b0, rx_cnt} + 9'(RX_STEP);

  wire rec_active = bus_off & ~reset_mode;
  wire run_done   = bit_tick & bit_recessive & (run_cnt == RUN_W'(IDLE_BITS - 1));
  wire recover    = rec_active & run_done & (idle_cnt == IDLE_W'(IDLE_RUNS - 1));

  wire warn = (tx_cnt >= WARN9) | ({1'b0, rx_cnt} >= WARN9);
  wire pass = (tx_cnt >= PASS9) | ({1'b0, rx_cnt} >= PASS9);

  logic [1:0] cur_st;
  always_comb begin
    if (bus_off)   cur_st = ST_BUSOFF;
    else if (pass) cur_st = 2'd2;
    else if (warn) cur_st = 2'd1;
    else           cur_st = 2'd0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_cnt  <= '0;
      rx_cnt  <= '0;
      bus_off <= 1'b0;
    end else if (bus_off) begin
      if (recover) begin
        tx_cnt  <= '0;
        rx_cnt  <= '0;
        bus_off <= 1'b0;
      end
    end else begin
      if (tx_err) begin
        if (tx_sum > 10'd255) begin
          tx_cnt  <= 9'd256;
          bus_off <= 1'b1;
        end else begin
          tx_cnt <= tx_sum[8:0];
        end
      end else if (tx_ok && tx_cnt != '0) begin
        tx_cnt <= tx_cnt - 9'd1;
      end
      if (rx_err)
        rx_cnt <= (rx_sum > 9'd255) ? 8'd255 : rx_sum[7:0];
      else if (rx_ok && rx_cnt != '0)
        rx_cnt <= rx_cnt - 8'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !rec_active) begin
      run_cnt  <= '0;
      idle_cnt <= '0;
    end else if (bit_tick) begin
      if (!bit_recessive) begin
        run_cnt <= '0;
      end else if (run_done) begin
        run_cnt  <= '0;
        idle_cnt <= recover ? '0 : idle_cnt + IDLE_W'(1);
      end else begin
        run_cnt <= run_cnt + RUN_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_st <= '0;
      drain_q <= 1'b0;
      code_q  <= '0;
    end else begin
      prev_st <= cur_st;
      drain_q <= recover;
      if (berr) code_q <= {berr_type, berr_rx, berr_seg};
    end
  end

  assign status    = {12'b0, bus_off, pass, warn, 1'b0,
                      bus_off ? 8'hFF : tx_cnt[7:0], rx_cnt};
  assign err_code  = code_q;
  assign state_evt = cur_st != prev_st;
  assign abort_all = bus_off & (prev_st != ST_BUSOFF);
  assign drain_req = drain_q;

  assert_busoff_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_off && !recover) |=> bus_off);
  assert_tx_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= 9'd256);
  assert_abort_in_busoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_all |-> status[19]);
  assert_drain_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    drain_req |-> (status[19:0] == 20'd0 && state_evt));
  assert_reset_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reset_mode |=> (idle_cnt == '0 && run_cnt == '0));
  assert_run_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt < RUN_W'(IDLE_BITS));

endmodule

// File: tb/tb_can_err_state.sv
`timescale 1ns/1ps
module tb_can_err_state;
  localparam int IB = 3;
  localparam int IR = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_err = 0, rx_err = 0, tx_ok = 0, rx_ok = 0;
  logic bit_tick = 0, bit_recessive = 0, reset_mode = 0;
  logic berr = 0, berr_rx = 0;
  logic [1:0] berr_type = 0;
  logic [4:0] berr_seg = 0;
  logic [31:0] status;
  logic [7:0] err_code;
  logic state_evt, abort_all, drain_req;

  can_err_state #(.IDLE_BITS(IB), .IDLE_RUNS(IR)) dut (
    .clk(clk), .rst_n(rst_n), .tx_err(tx_err), .rx_err(rx_err),
    .tx_ok(tx_ok), .rx_ok(rx_ok), .bit_tick(bit_tick),
    .bit_recessive(bit_recessive), .reset_mode(reset_mode),
    .berr(berr), .berr_rx(berr_rx), .berr_type(berr_type),
    .berr_seg(berr_seg), .status(status), .err_code(err_code),
    .state_evt(state_evt), .abort_all(abort_all), .drain_req(drain_req));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_err = 0;
  int m_tx = 0, m_rx = 0, m_run = 0, m_idle = 0, m_prev = 0;
  bit m_bo = 0;
  logic [7:0] m_code = 0;
  logic [15:0] lf = 16'hACE1;
  bit done = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(bit te, bit re, bit tk, bit rk, bit tick, bit rec, bit rm,
                      bit be, bit brx, logic [1:0] bty, logic [4:0] bseg);
    bit exp_drain, warn_e, pass_e, exp_evt, exp_abort;
    int st;
    tx_err = te; rx_err = re; tx_ok = tk; rx_ok = rk;
    bit_tick = tick; bit_recessive = rec; reset_mode = rm;
    berr = be; berr_rx = brx; berr_type = bty; berr_seg = bseg;
    @(posedge clk);
    exp_drain = 0;
    if (!m_bo) begin
      if (te) begin
        if (m_tx + 8 > 255) begin m_tx = 256; m_bo = 1; end
        else m_tx += 8;
      end else if (tk && m_tx > 0) m_tx--;
      if (re) m_rx = (m_rx + 1 > 255) ? 255 : m_rx + 1;
      else if (rk && m_rx > 0) m_rx--;
    end else if (rm) begin
      m_run = 0; m_idle = 0;
    end else if (tick) begin
      if (!rec) m_run = 0;
      else if (m_run == IB - 1) begin
        m_run = 0;
        if (m_idle == IR - 1) begin
          m_idle = 0; m_tx = 0; m_rx = 0; m_bo = 0; exp_drain = 1;
        end else m_idle++;
      end else m_run++;
    end
    if (be) m_code = {bty, brx, bseg};
    warn_e = (m_tx >= 96) || (m_rx >= 96);
    pass_e = (m_tx >= 128) || (m_rx >= 128);
    st = m_bo ? 3 : pass_e ? 2 : warn_e ? 1 : 0;
    exp_evt = (st != m_prev);
    exp_abort = m_bo && (m_prev != 3);
    m_prev = st;
    @(negedge clk);
    check("R2 counters", {16'b0, status[15:0]},
          {16'b0, m_bo ? 8'hFF : 8'(m_tx), 8'(m_rx)});
    check("R3 warning", {31'b0, status[17]}, {31'b0, warn_e});
    check("R4 passive", {31'b0, status[18]}, {31'b0, pass_e});
    check("R5 busoff", {31'b0, status[19]}, {31'b0, m_bo});
    check("R1 reserved", {19'b0, status[31:20], status[16]}, 32'b0);
    check("R6 state_evt", {31'b0, state_evt}, {31'b0, exp_evt});
    check("R7 abort_all", {31'b0, abort_all}, {31'b0, exp_abort});
    check("R9 drain_req", {31'b0, drain_req}, {31'b0, exp_drain});
    check("R10 err_code", {24'b0, err_code}, {24'b0, m_code});
  endtask

  task automatic idle_step();
    step(0,0,0,0,0,0,0,0,0,2'b0,5'b0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    check("R11 status", status, 32'b0);
    check("R11 err_code", {24'b0, err_code}, 32'b0);
    check("R11 pulses", {29'b0, state_evt, abort_all, drain_req}, 32'b0);
    rst_n = 1'b1;

    // R2/R3/R4: receive counter ramp past saturation then back to zero
    for (int i = 0; i < 300; i++) step(0,1,0,0,0,0,0,0,0,2'b0,5'b0);
    for (int i = 0; i < 300; i++) step(0,0,0,1,0,0,0,0,0,2'b0,5'b0);
    // R2: error beats success on the same counter
    for (int i = 0; i < 5; i++) step(1,1,1,1,0,0,0,0,0,2'b0,5'b0);
    for (int i = 0; i < 50; i++) step(0,0,1,1,0,0,0,0,0,2'b0,5'b0);

    // R10: every error code combination, then a cycle without strobe
    for (int i = 0; i < 256; i++) begin
      logic [7:0] c = 8'(i);
      step(0,0,0,0,0,0,0,1,c[5],c[7:6],c[4:0]);
      step(0,0,0,0,0,0,0,0,~c[5],~c[7:6],~c[4:0]);
    end

    // Pseudo-random stream: R5 R6 R7 R8 R9
    for (int i = 0; i < 6000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[1:0] == 2'b0, lf[12], lf[3:2] == 2'b0, lf[13],
           lf[8], lf[11:9] != 3'b0, lf[7:4] == 4'b0,
           lf[14], lf[15], lf[6:5], lf[4:0]);
    end

    // Directed R8: bus-off held in reset mode, dominant break late in a run
    for (int i = 0; i < 40; i++) step(1,0,0,0,0,0,0,0,0,2'b0,5'b0);
    for (int i = 0; i < 20; i++) step(0,0,0,0,1,1,1,0,0,2'b0,5'b0);
    check("R8 held in reset mode", {31'b0, status[19]}, 32'd1);
    for (int i = 0; i < IB - 1; i++) step(0,0,0,0,1,1,0,0,0,2'b0,5'b0);
    step(0,0,0,0,1,0,0,0,0,2'b0,5'b0);
    for (int i = 0; i < IB * IR - 1; i++) begin
      step(0,0,0,0,1,1,0,0,0,2'b0,5'b0);
      step(0,0,0,0,0,1,0,0,0,2'b0,5'b0);
    end
    check("R8 one tick short", {31'b0, status[19]}, 32'd1);
    step(0,0,0,0,1,1,0,0,0,2'b0,5'b0);
    check("R9 recovered", status, 32'b0);
    for (int i = 0; i < 4; i++) idle_step();

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule